// File: doc/BRIEF.md
# Serial Audio Transmit Status Controller

This block holds the transmit-side status flags, the interrupt mapping and the enable/soft-reset control of a synchronous serial audio port with one or two channels. A small register bus sets a global enable, transmit and receive enables, a channel-count selector and a transmit interrupt enable. Per-channel strobes report writes into each channel's transmit holding register. A per-channel slot request marks the moment the serial shifter wants the next word. From these inputs the block keeps, for each channel, a "holding register empty" flag and an "underrun" flag.

Each channel drives two interrupt lines. One fires for an empty register with a pending underrun. The other fires for an empty register with no underrun. Clearing the global enable returns every status flag to its power-on value and leaves the control settings as they were. The channel-count selector and the interrupt enable are configuration bits: they are frozen while the global enable is set. The serial shifter, bit-clock generation, frame formats and DMA live elsewhere. This block only drives `tx_run`/`rx_run` to them.

Top module: `sai_tx_status`

## Requirements
- R1: A synchronous active-low `rst_n` returns the control byte to 0x00, the interrupt-enable byte to 0x00, both empty flags to 1, both underrun flags to 0, and every interrupt output to 0.
- R2: The register map is as follows. Address 0 holds control: bit0 global enable, bit1 transmit enable, bit2 receive enable, bit3 two-channel mode. Address 1 holds bit0, the transmit interrupt enable. Address 2 holds status: bit0/bit1 are the channel 0/1 empty flags and bit2/bit3 are the channel 0/1 underrun flags. Address 3 and every unlisted bit read 0. `bus_rdata` follows `bus_addr` combinationally.
- R3: While the registered global enable is 1, writes to the two-channel bit and to the interrupt-enable byte are ignored. The global, transmit and receive enables stay writable at all times.
- R4: `tx_run` equals global enable AND transmit enable, and `rx_run` equals global enable AND receive enable. A transmit enable set while the global enable is 0 consumes no data and raises no underrun.
- R5: With the port enabled and the channel active, a data-write strobe clears that channel's empty flag on the next clock edge.
- R6: With `tx_run` high, a slot request sets the empty flag of a channel whose flag is 0. It raises the underrun flag of a channel whose flag is already 1. With `tx_run` low, slot requests change nothing.
- R7: Writing 1 to status bit2/bit3 clears that channel's underrun flag. Writes to the empty bits have no effect. An underrun raised in the same cycle wins over the clear.
- R8: For an active channel, `irq_exc` = interrupt enable AND underrun AND empty, and `irq_plain` = interrupt enable AND empty AND NOT underrun.
- R9: One cycle after the registered global enable reads 0, and for as long as it stays 0, the status flags hold their R1 values. The control byte and the interrupt enable keep their contents.
- R10: With the two-channel bit at 0, channel 1 keeps its R1 flag values, ignores its data and slot inputs, and drives both of its interrupts low.
- R11: When a data write and a slot request reach the same channel in one cycle, the empty flag ends at 0. An underrun is still raised if the flag was 1 beforehand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on `bus_addr`) |
| dat_wr | input | NUM_CH | Per-channel transmit holding register write strobe |
| slot_req | input | NUM_CH | Per-channel request for the next transmit word |
| tx_run | output | 1 | Transmit path effectively enabled |
| rx_run | output | 1 | Receive path effectively enabled |
| irq_exc | output | NUM_CH | Per-channel empty-with-underrun interrupt |
| irq_plain | output | NUM_CH | Per-channel empty-without-underrun interrupt |

## Verification
The bench targets the configuration lock. A design that let the two-channel bit or the interrupt enable change while enabled would show new read-back values or new interrupts in the middle of operation. It also covers the case of a write, a slot request and an underrun clear landing in the same cycle. Getting the priority wrong there would leave a channel wrongly empty or silently lose an underrun. The soft reset and single-channel mode are checked for status being reset while control survives, and for a dormant channel 1 raising an interrupt. A free-running phase with random bus, strobe and slot traffic is compared every cycle against a behavioural model, to catch mis-routed status bits and swapped interrupt variants.

// File: rtl/sai_tx_pkg.sv
`timescale 1ns/1ps
// Package: shared register addresses, bit positions and the control type
// for the serial audio transmit status controller.
// Assumes a byte-wide register bus and at most two channels.
package sai_tx_pkg;
    localparam int REG_AW  = 2;
    localparam int REG_DW  = 8;
    localparam int MAX_CH  = 2;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_IEN  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;

    localparam int CB_GLB  = 0;
    localparam int CB_TX   = 1;
    localparam int CB_RX   = 2;
    localparam int CB_DUAL = 3;

    localparam int SB_EMPTY_BASE = 0;
    localparam int SB_UND_BASE   = MAX_CH;

    typedef struct packed {
        logic dual;
        logic rx_en;
        logic tx_en;
        logic glb_en;
    } ctrl_t;
endpackage

// File: rtl/sai_tx_ctrl_regs.sv
`timescale 1ns/1ps
// Module: control and interrupt-enable registers.
// Holds the global/transmit/receive enables, the two-channel selector and
// the transmit interrupt enable. The selector and interrupt enable are
// configuration bits that only accept writes while the registered global
// enable is 0. Assumes a single-cycle write strobe with address and data.
module sai_tx_ctrl_regs
    import sai_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    output ctrl_t             ctrl,
    output logic              tie
);
    logic wr_ctrl;
    logic wr_ien;
    logic cfg_open;
    logic unused_wdata;

    assign wr_ctrl  = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_ien   = bus_we && (bus_addr == ADDR_IEN);
    assign cfg_open = !ctrl.glb_en;
    assign unused_wdata = ^bus_wdata[REG_DW-1:4];

    // Purpose: update enables always, configuration bits only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            tie  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.glb_en <= bus_wdata[CB_GLB];
                ctrl.tx_en  <= bus_wdata[CB_TX];
                ctrl.rx_en  <= bus_wdata[CB_RX];
                if (cfg_open) begin
                    ctrl.dual <= bus_wdata[CB_DUAL];
                end
            end
            if (wr_ien && cfg_open) begin
                tie <= bus_wdata[0];
            end
        end
    end

    // R3: configuration bits never move while the port is enabled
    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.glb_en |=> ($stable(ctrl.dual) && $stable(tie)));
endmodule

// File: rtl/sai_tx_chan_flags.sv
`timescale 1ns/1ps
// Module: per-channel empty and underrun flags.
// Empty is set on reset and when the shifter consumes a word. A data write
// clears it and wins over a same-cycle consumption. Underrun is raised
// by a slot request on an empty register and cleared by a write-one
// strobe, with the raise winning. clear_i forces the power-on values
// (soft reset or inactive channel). Assumes run_i already includes the
// global enable.
module sai_tx_chan_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic dat_wr_i,
    input  logic slot_i,
    input  logic und_clr_i,
    output logic empty_o,
    output logic under_o
);
    logic take;

    assign take = run_i && slot_i;

    // Purpose: track holding-register occupancy and the underrun exception.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            empty_o <= 1'b1;
            under_o <= 1'b0;
        end else begin
            if (dat_wr_i) begin
                empty_o <= 1'b0;
            end else if (take) begin
                empty_o <= 1'b1;
            end
            if (take && empty_o) begin
                under_o <= 1'b1;
            end else if (und_clr_i) begin
                under_o <= 1'b0;
            end
        end
    end

    // R5: a data write on a live channel empties nothing on the next edge
    assert_wr_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && dat_wr_i) |=> !empty_o);

    // R6: a slot request on an empty live register raises underrun
    assert_slot_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && run_i && slot_i && empty_o) |=> under_o);

    // R7: a clear with no competing raise removes the underrun
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && und_clr_i && !(run_i && slot_i && empty_o)) |=> !under_o);

    // R9: soft reset lands on the power-on flag values
    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (empty_o && !under_o));
endmodule

// File: rtl/sai_tx_irq_map.sv
`timescale 1ns/1ps
// Module: maps per-channel flags to the two interrupt variants.
// An inactive channel drives both lines low. Assumes flags are registered
// upstream, so the outputs are glitch-free combinations of flops.
module sai_tx_irq_map #(
    parameter int NUM_CH = 2
) (
    input  logic              tie,
    input  logic [NUM_CH-1:0] active,
    input  logic [NUM_CH-1:0] empty,
    input  logic [NUM_CH-1:0] under,
    output logic [NUM_CH-1:0] irq_exc,
    output logic [NUM_CH-1:0] irq_plain
);
    // Purpose: split each channel's empty request by its exception status.
    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            irq_exc[ch]   = tie && active[ch] && empty[ch] &&  under[ch];
            irq_plain[ch] = tie && active[ch] && empty[ch] && !under[ch];
        end
    end
endmodule

// File: rtl/sai_tx_status.sv
`timescale 1ns/1ps
// Module: top of the serial audio transmit status controller.
// Combines the control registers, one flag tracker per channel and the
// interrupt map, and serves register reads. Channel 0 is always active.
// Channel 1 is active only in two-channel mode. Assumes NUM_CH is 1 or 2.
module sai_tx_status
    import sai_tx_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_CH-1:0] dat_wr,
    input  logic [NUM_CH-1:0] slot_req,
    output logic              tx_run,
    output logic              rx_run,
    output logic [NUM_CH-1:0] irq_exc,
    output logic [NUM_CH-1:0] irq_plain
);
    ctrl_t             ctrl;
    logic              tie;
    logic [NUM_CH-1:0] active;
    logic [NUM_CH-1:0] empty;
    logic [NUM_CH-1:0] under;
    logic [REG_DW-1:0] stat_byte;
    logic              stat_wr;

    assign tx_run  = ctrl.glb_en && ctrl.tx_en;
    assign rx_run  = ctrl.glb_en && ctrl.rx_en;
    assign stat_wr = bus_we && (bus_addr == ADDR_STAT);

    sai_tx_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl      (ctrl),
        .tie       (tie)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        if (ch == 0) begin : g_primary
            assign active[ch] = 1'b1;
        end else begin : g_secondary
            assign active[ch] = ctrl.dual;
        end

        sai_tx_chan_flags u_flags (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (!ctrl.glb_en || !active[ch]),
            .run_i     (tx_run),
            .dat_wr_i  (dat_wr[ch]),
            .slot_i    (slot_req[ch]),
            .und_clr_i (stat_wr && bus_wdata[SB_UND_BASE + ch]),
            .empty_o   (empty[ch]),
            .under_o   (under[ch])
        );
    end

    sai_tx_irq_map #(.NUM_CH(NUM_CH)) u_irq (
        .tie       (tie),
        .active    (active),
        .empty     (empty),
        .under     (under),
        .irq_exc   (irq_exc),
        .irq_plain (irq_plain)
    );

    // Purpose: place each channel's flags at their fixed status bit positions.
    always_comb begin
        stat_byte = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            stat_byte[SB_EMPTY_BASE + ch] = empty[ch];
            stat_byte[SB_UND_BASE + ch]   = under[ch];
        end
    end

    // Purpose: combinational register read mux.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {4'b0, ctrl};
            ADDR_IEN:  bus_rdata = {7'b0, tie};
            ADDR_STAT: bus_rdata = stat_byte;
            default:   bus_rdata = '0;
        endcase
    end

    if (NUM_CH > 1) begin : g_single_chk
        // R10: dormant second channel stays at reset values and silent
        assert_ch1_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl.dual |-> (empty[1] && !under[1] && !irq_exc[1] && !irq_plain[1]));
    end
endmodule

// File: tb/sai_tx_status_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios plus random traffic, every cycle compared with
// a behavioural model of the requirements.
module sai_tx_status_tb;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_we = 1'b0;
    logic [1:0]     bus_addr = 2'd0;
    logic [7:0]     bus_wdata = 8'd0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] dat_wr = '0;
    logic [NCH-1:0] slot_req = '0;
    logic           tx_run;
    logic           rx_run;
    logic [NCH-1:0] irq_exc;
    logic [NCH-1:0] irq_plain;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sai_tx_status #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dat_wr(dat_wr),
        .slot_req(slot_req), .tx_run(tx_run), .rx_run(rx_run),
        .irq_exc(irq_exc), .irq_plain(irq_plain)
    );

    // Behavioural model state
    bit m_glb, m_tx, m_rx, m_dual, m_tie;
    bit [1:0] m_emp, m_und;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_glb = 0; m_tx = 0; m_rx = 0; m_dual = 0; m_tie = 0;
            m_emp = 2'b11; m_und = 2'b00;
        end else begin
            bit og, od, orun;
            bit [1:0] oe, ou;
            og = m_glb; od = m_dual; orun = m_glb && m_tx; oe = m_emp; ou = m_und;
            if (bus_we && bus_addr == 2'd0) begin
                m_glb = bus_wdata[0]; m_tx = bus_wdata[1]; m_rx = bus_wdata[2];
                if (!og) m_dual = bus_wdata[3];
            end
            if (bus_we && bus_addr == 2'd1 && !og) m_tie = bus_wdata[0];
            for (int c = 0; c < NCH; c++) begin
                if (!og || (c == 1 && !od)) begin
                    m_emp[c] = 1; m_und[c] = 0;
                end else begin
                    if (slot_req[c] && orun && oe[c]) m_und[c] = 1;
                    else if (bus_we && bus_addr == 2'd2 && bus_wdata[2+c]) m_und[c] = 0;
                    if (dat_wr[c]) m_emp[c] = 0;
                    else if (slot_req[c] && orun) m_emp[c] = 1;
                    else m_emp[c] = oe[c];
                    if (ou[c] && !(bus_we && bus_addr == 2'd2 && bus_wdata[2+c])
                        && !(slot_req[c] && orun && oe[c])) m_und[c] = 1;
                end
            end
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_dual, m_rx, m_tx, m_glb};
            2'd1: return {7'b0, m_tie};
            2'd2: return {4'b0, m_und, m_emp};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [1:0] ex, ep;
        for (int c = 0; c < NCH; c++) begin
            bit act = (c == 0) || m_dual;
            ex[c] = act && m_tie && m_emp[c] && m_und[c];
            ep[c] = act && m_tie && m_emp[c] && !m_und[c];
        end
        chk("R2 model rdata", bus_rdata, exp_rd(bus_addr));
        chk("R4 model tx_run", tx_run, m_glb && m_tx);
        chk("R4 model rx_run", rx_run, m_glb && m_rx);
        chk("R8 model irq_exc", irq_exc, ex);
        chk("R8 model irq_plain", irq_plain, ep);
    endtask

    task automatic cyc(input bit we, input logic [1:0] a, input logic [7:0] wd,
                       input logic [1:0] dw, input logic [1:0] sl);
        bus_we = we; bus_addr = a; bus_wdata = wd; dat_wr = dw; slot_req = sl;
        @(posedge clk);
        @(negedge clk);
        bus_we = 0; dat_wr = '0; slot_req = '0;
        compare_all();
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);
        rd(0, 8'h00, "R1 ctrl reset");
        rd(1, 8'h00, "R1 ien reset");
        rd(2, 8'h03, "R1 status reset");
        chk("R1 irq_plain reset", irq_plain, 0);

        cyc(1, 1, 8'h01, 0, 0);
        chk("R10 only ch0 plain irq in single mode", irq_plain, 2'b01);
        cyc(1, 0, 8'h0A, 0, 0);
        chk("R4 tx_run low without global enable", tx_run, 0);
        chk("R8 both plain irqs after dual set", irq_plain, 2'b11);
        cyc(0, 0, 0, 0, 2'b11);
        rd(2, 8'h03, "R4 no underrun while globally disabled");

        cyc(1, 0, 8'h0B, 0, 0);
        chk("R4 tx_run after global enable", tx_run, 1);
        cyc(1, 0, 8'h03, 0, 0);
        rd(0, 8'h0B, "R3 dual bit locked while enabled");
        cyc(1, 1, 8'h00, 0, 0);
        rd(1, 8'h01, "R3 interrupt enable locked while enabled");

        cyc(0, 2, 0, 2'b01, 0);
        rd(2, 8'h02, "R5 write clears ch0 empty");
        chk("R5 ch0 plain irq removed", irq_plain, 2'b10);
        cyc(0, 2, 0, 0, 2'b01);
        rd(2, 8'h03, "R6 slot consumes ch0 word");
        cyc(0, 2, 0, 0, 2'b01);
        rd(2, 8'h07, "R6 slot on empty raises ch0 underrun");
        chk("R8 exception irq ch0", irq_exc, 2'b01);
        chk("R8 plain irq ch0 off during underrun", irq_plain, 2'b10);

        cyc(1, 2, 8'h03, 0, 0);
        rd(2, 8'h07, "R7 empty bits not writable");
        cyc(1, 2, 8'h04, 0, 2'b01);
        rd(2, 8'h07, "R7 raise wins over clear");
        cyc(1, 2, 8'h04, 0, 0);
        rd(2, 8'h03, "R7 write-one clears ch0 underrun");

        cyc(0, 2, 0, 2'b10, 2'b10);
        rd(2, 8'h09, "R11 write wins, underrun still raised");
        cyc(0, 2, 0, 2'b10, 2'b10);
        rd(2, 8'h09, "R11 write and take on full register");

        cyc(1, 0, 8'h01, 0, 0);
        rd(0, 8'h09, "R3 dual kept, tx cleared");
        cyc(0, 2, 0, 0, 2'b11);
        rd(2, 8'h09, "R6 slots ignored with transmit off");

        cyc(1, 0, 8'h00, 0, 0);
        cyc(0, 2, 0, 0, 0);
        rd(2, 8'h03, "R9 soft reset restores status");
        rd(0, 8'h08, "R9 control kept over soft reset");
        rd(1, 8'h01, "R9 interrupt enable kept");

        cyc(1, 0, 8'h00, 0, 0);
        cyc(1, 0, 8'h03, 0, 0);
        cyc(0, 2, 0, 2'b11, 0);
        rd(2, 8'h02, "R10 ch1 write ignored in single mode");
        chk("R10 no plain irq on ch1", irq_plain, 2'b00);
        cyc(0, 2, 0, 0, 2'b10);
        rd(2, 8'h02, "R10 ch1 slot ignored in single mode");
        chk("R10 no exception irq on ch1", irq_exc, 2'b00);
        rd(3, 8'h00, "R2 unused address reads zero");

        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        rd(0, 8'h00, "R1 ctrl after second reset");
        rd(1, 8'h00, "R1 ien after second reset");
        rd(2, 8'h03, "R1 status after second reset");

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] wd;
            logic [1:0] a;
            bit we;
            wd = 8'($urandom);
            a  = 2'($urandom);
            we = ($urandom % 4) == 0;
            if (a == 2'd0 && ($urandom % 3) != 0) wd[0] = 1'b1;
            cyc(we, a, wd, 2'($urandom), 2'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule